// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block decides where a single-cycle 32-bit core fetches next. It is purely combinational. Each cycle it receives the current program counter, the two register operands, an immediate that has already been sign-extended, a two-bit flow class and the three-bit condition code of the instruction. It returns the next program counter, the return address for a link write, a write-enable for that link, a taken flag and an illegal-condition flag.

The four flow classes are sequential, conditional branch, direct jump-and-link, and register jump-and-link. A conditional branch compares the operands in one of six ways: equality, inequality, two's-complement less-than and greater-or-equal, and magnitude less-than and greater-or-equal. A branch target is PC-relative, with the offset counted in halfwords. A direct jump adds the byte offset to the PC. A register jump adds the immediate to the first operand and clears bit 0 of the sum.

The unit has no internal state, so there is no state machine and no reset. It settles within the cycle in which its inputs are presented.

Top module: `npc_unit`

## Requirements
- R1: With flow class 00 (sequential), `next_pc_o` is `pc_i + 4` (wrapping modulo 2^32), `taken_o` is 0 and `link_we_o` is 0, whatever the condition code and operands are.
- R2: With flow class 01 (branch) and a condition that holds, `next_pc_o` is `pc_i + (imm_i << 1)` and `taken_o` is 1. For example, an immediate of 64 moves the PC by 128.
- R3: With flow class 01 and a condition that does not hold, `next_pc_o` is `pc_i + 4` and `taken_o` is 0.
- R4: Condition code 000 holds when the operands are equal. Condition code 001 holds when they differ.
- R5: Condition code 100 holds when `opa_i < opb_i` as two's-complement numbers. Condition code 101 holds when `opa_i >= opb_i` as two's-complement numbers.
- R6: Condition code 110 holds when `opa_i < opb_i` as unsigned magnitudes. Condition code 111 holds when `opa_i >= opb_i` as unsigned magnitudes.
- R7: In flow class 01, condition codes 010 and 011 never hold, and `illegal_o` is 1. In every other case `illegal_o` is 0, including when a jump class carries those codes.
- R8: With flow class 10 (direct jump), `next_pc_o` is `pc_i + imm_i` and `taken_o` is 1.
- R9: With flow class 11 (register jump), `next_pc_o` is `opa_i + imm_i` with bit 0 cleared, and `taken_o` is 1.
- R10: `link_o` is always `pc_i + 4`. `link_we_o` is 1 exactly for flow classes 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Current program counter |
| opa_i | input | 32 | First register operand; also the base address for a register jump |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 32 | Sign-extended immediate |
| kind_i | input | 2 | Flow class: 00 sequential, 01 branch, 10 direct jump, 11 register jump |
| cond_i | input | 3 | Branch condition code |
| next_pc_o | output | 32 | Address of the next fetch |
| link_o | output | 32 | Return address (PC + 4) |
| link_we_o | output | 1 | Write-enable for the return address |
| taken_o | output | 1 | Control leaves the sequential path |
| illegal_o | output | 1 | A branch used a reserved condition code |

## Verification
The comparator and the jump path both see every instruction. When a jump class arrives with a condition code and operands that would make a branch hold, or a reserved code that would flag an illegal branch, both functions act in the same cycle. The bench provokes this by sending direct and register jumps that carry codes 000 and 010 with equal operands. The outputs must then show only the jump: the jump target, `taken_o` high, `link_we_o` high and `illegal_o` low. The sequential class is driven with a condition that holds, and `next_pc_o` must stay at PC + 4.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [1:0] {
        FLOW_SEQ    = 2'b00,
        FLOW_BRANCH = 2'b01,
        FLOW_JAL    = 2'b10,
        FLOW_JALR   = 2'b11
    } flow_kind_e;

    typedef enum logic [2:0] {
        CND_EQ   = 3'b000,
        CND_NE   = 3'b001,
        CND_RSV2 = 3'b010,
        CND_RSV3 = 3'b011,
        CND_LT   = 3'b100,
        CND_GE   = 3'b101,
        CND_LTU  = 3'b110,
        CND_GEU  = 3'b111
    } cond_code_e;

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  cond_code_e      code,
    output logic            holds,
    output logic            reserved
);

    logic same;
    logic below_s;
    logic below_u;

    always_comb begin
        same    = (opa == opb);
        below_s = ($signed(opa) < $signed(opb));
        below_u = (opa < opb);
    end

    always_comb begin
        holds    = 1'b0;
        reserved = 1'b0;
        unique case (code)
            CND_EQ:   holds = same;
            CND_NE:   holds = !same;
            CND_LT:   holds = below_s;
            CND_GE:   holds = !below_s;
            CND_LTU:  holds = below_u;
            CND_GEU:  holds = !below_u;
            CND_RSV2,
            CND_RSV3: reserved = 1'b1;
        endcase
    end

    // R7: a reserved code never reports a holding condition
    always_comb begin
        assert_reserved_never_holds_R7: assert (!(reserved && holds))
            else $error("reserved condition reported as holding");
    end

endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] imm,
    input  flow_kind_e      kind,
    input  logic            br_hit,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] ret_addr
);

    localparam int STEP = XLEN / 8;
    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] br_addr;
    logic [XLEN-1:0] jal_addr;
    logic [XLEN-1:0] reg_sum;
    logic [XLEN-1:0] jalr_addr;

    always_comb begin
        seq_addr  = pc + STEP_V;
        br_addr   = pc + {imm[XLEN-2:0], 1'b0};
        jal_addr  = pc + imm;
        reg_sum   = base + imm;
        jalr_addr = {reg_sum[XLEN-1:1], 1'b0};
    end

    always_comb begin
        ret_addr = seq_addr;
        unique case (kind)
            FLOW_SEQ:    next_pc = seq_addr;
            FLOW_BRANCH: next_pc = br_hit ? br_addr : seq_addr;
            FLOW_JAL:    next_pc = jal_addr;
            FLOW_JALR:   next_pc = jalr_addr;
        endcase
    end

    // R9: a register jump always lands on an even address
    always_comb begin
        assert_jalr_even_R9: assert (!(kind == FLOW_JALR) || next_pc[0] == 1'b0)
            else $error("register jump target is odd");
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    input  logic [XLEN-1:0] imm_i,
    input  logic [1:0]      kind_i,
    input  logic [2:0]      cond_i,
    output logic [XLEN-1:0] next_pc_o,
    output logic [XLEN-1:0] link_o,
    output logic            link_we_o,
    output logic            taken_o,
    output logic            illegal_o
);

    localparam logic [XLEN-1:0] STEP_V = XLEN'(XLEN / 8);

    flow_kind_e kind;
    cond_code_e code;
    logic       cond_holds;
    logic       cond_reserved;
    logic       is_branch;
    logic       is_jump;

    always_comb begin
        kind      = flow_kind_e'(kind_i);
        code      = cond_code_e'(cond_i);
        is_branch = (kind == FLOW_BRANCH);
        is_jump   = (kind == FLOW_JAL) || (kind == FLOW_JALR);
    end

    npc_cond #(.XLEN(XLEN)) u_cond (
        .opa      (opa_i),
        .opb      (opb_i),
        .code     (code),
        .holds    (cond_holds),
        .reserved (cond_reserved)
    );

    npc_target #(.XLEN(XLEN)) u_target (
        .pc       (pc_i),
        .base     (opa_i),
        .imm      (imm_i),
        .kind     (kind),
        .br_hit   (is_branch && cond_holds),
        .next_pc  (next_pc_o),
        .ret_addr (link_o)
    );

    always_comb begin
        taken_o   = is_jump || (is_branch && cond_holds);
        link_we_o = is_jump;
        illegal_o = is_branch && cond_reserved;
    end

    always_comb begin
        // R1: the sequential class steps by one instruction and is never taken
        assert_seq_step_R1: assert (!(kind == FLOW_SEQ) || (next_pc_o == pc_i + STEP_V && !taken_o))
            else $error("sequential step wrong");
        // R10: the return address is PC + 4 for every class
        assert_link_value_R10: assert (link_o == pc_i + STEP_V)
            else $error("link value wrong");
        // R10: a link write only happens together with a taken jump
        assert_link_we_taken_R10: assert (!link_we_o || taken_o)
            else $error("link write without taken jump");
        // R7: an illegal branch falls through
        assert_illegal_falls_R7: assert (!illegal_o || (!taken_o && next_pc_o == pc_i + STEP_V))
            else $error("illegal branch redirected");
        // R3: a branch that is not taken falls through
        assert_branch_fall_R3: assert (!(is_branch && !taken_o) || next_pc_o == pc_i + STEP_V)
            else $error("untaken branch redirected");
    end

endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [31:0] pc_i, opa_i, opb_i, imm_i;
    logic [1:0]  kind_i;
    logic [2:0]  cond_i;
    logic [31:0] next_pc_o, link_o;
    logic        link_we_o, taken_o, illegal_o;

    npc_unit #(.XLEN(32)) u_dut (
        .pc_i      (pc_i),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .imm_i     (imm_i),
        .kind_i    (kind_i),
        .cond_i    (cond_i),
        .next_pc_o (next_pc_o),
        .link_o    (link_o),
        .link_we_o (link_we_o),
        .taken_o   (taken_o),
        .illegal_o (illegal_o)
    );

    typedef struct {
        logic [66:0] vec;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    task automatic send(input logic [1:0] k, input logic [2:0] c,
                        input logic [31:0] pc, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] im,
                        input logic [31:0] exp_next, input logic exp_taken,
                        input logic exp_we, input logic exp_ill, input string tag);
        exp_t e;
        @(negedge clk);
        kind_i = k; cond_i = c; pc_i = pc; opa_i = a; opb_i = b; imm_i = im;
        e.vec = {exp_next, pc + 32'd4, exp_we, exp_taken, exp_ill};
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    always @(posedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [66:0] got;
            e   = exp_q.pop_front();
            got = {next_pc_o, link_o, link_we_o, taken_o, illegal_o};
            n_checks++;
            if (got !== e.vec) begin
                n_fail++;
                $display("FAIL %s: got next=%h link=%h we=%b tk=%b il=%b, expected next=%h link=%h we=%b tk=%b il=%b",
                         e.tag, got[66:35], got[34:3], got[2], got[1], got[0],
                         e.vec[66:35], e.vec[34:3], e.vec[2], e.vec[1], e.vec[0]);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        kind_i = 2'b00; cond_i = 3'b000; pc_i = '0; opa_i = '0; opb_i = '0; imm_i = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state, R1 / R10
        send(2'b00, 3'b000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h4, 0, 0, 0, "R1 reset state");
        send(2'b00, 3'b000, 32'h100, 32'h7, 32'h7, 32'h40, 32'h104, 0, 0, 0, "R1 seq ignores holding cond");
        send(2'b00, 3'b010, 32'hFFFF_FFFC, 32'h0, 32'h0, 32'h0, 32'h0, 0, 0, 0, "R1 seq wrap, R7 no illegal");
        // equality codes
        send(2'b01, 3'b000, 32'h1000, 32'h5, 32'h5, 32'd64, 32'h1080, 1, 0, 0, "R2 R4 eq taken");
        send(2'b01, 3'b000, 32'h1000, 32'h5, 32'h6, 32'd64, 32'h1004, 0, 0, 0, "R3 R4 eq not taken");
        send(2'b01, 3'b001, 32'h200, 32'h1, 32'h2, 32'hFFFF_FFF8, 32'h1F0, 1, 0, 0, "R2 R4 ne backward");
        send(2'b01, 3'b001, 32'h200, 32'h9, 32'h9, 32'hFFFF_FFF8, 32'h204, 0, 0, 0, "R3 R4 ne not taken");
        // signed
        send(2'b01, 3'b100, 32'h300, 32'hFFFF_FFFF, 32'h1, 32'h4, 32'h308, 1, 0, 0, "R5 lt signed");
        send(2'b01, 3'b101, 32'h300, 32'hFFFF_FFFF, 32'h1, 32'h10, 32'h304, 0, 0, 0, "R5 ge signed false");
        send(2'b01, 3'b101, 32'h300, 32'h8000_0000, 32'h8000_0000, 32'h10, 32'h320, 1, 0, 0, "R5 ge signed equal");
        // unsigned
        send(2'b01, 3'b110, 32'h300, 32'hFFFF_FFFF, 32'h1, 32'h10, 32'h304, 0, 0, 0, "R6 ltu false");
        send(2'b01, 3'b111, 32'h300, 32'hFFFF_FFFF, 32'h1, 32'h10, 32'h320, 1, 0, 0, "R6 geu true");
        send(2'b01, 3'b110, 32'h300, 32'h0, 32'h1, 32'h10, 32'h320, 1, 0, 0, "R6 ltu true");
        // reserved
        send(2'b01, 3'b010, 32'h400, 32'h3, 32'h3, 32'h10, 32'h404, 0, 0, 1, "R7 code 010");
        send(2'b01, 3'b011, 32'h400, 32'h3, 32'h4, 32'h10, 32'h404, 0, 0, 1, "R7 code 011");
        // direct jumps
        send(2'b10, 3'b000, 32'h500, 32'h0, 32'h1, 32'd16, 32'h510, 1, 1, 0, "R8 R10 jal forward");
        send(2'b10, 3'b010, 32'h500, 32'h3, 32'h3, 32'hFFFF_FF00, 32'h400, 1, 1, 0, "R8 R7 jal with reserved code");
        // register jumps
        send(2'b11, 3'b000, 32'h600, 32'h1001, 32'h1001, 32'h2, 32'h1002, 1, 1, 0, "R9 jalr clears bit0");
        send(2'b11, 3'b011, 32'h600, 32'h2000, 32'h0, 32'hFFFF_FFFF, 32'h1FFE, 1, 1, 0, "R9 R7 jalr negative imm");
        send(2'b11, 3'b000, 32'hFFFF_FFFC, 32'h40, 32'h0, 32'h0, 32'h40, 1, 1, 0, "R9 R10 jalr link wrap");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule